// File: doc/BRIEF.md
# Eight-Bit ALU With Status Flags

This block is the arithmetic and logic stage of a small eight-bit datapath. Each time `go` is high at a rising clock edge it combines the accumulator value (`acc_in`) with a second operand (`opnd_in`), under the operation selected by `op_sel`. For the carry-using operations it also takes the incoming carry (`cy_in`). One cycle later it presents the registered result, a write strobe for the accumulator, and a status byte.

The status byte holds five flags: sign, zero, parity, nibble (auxiliary) carry and carry. Software can read it directly. Its three spare bit positions always carry fixed values.

Compare works out the difference only to set the flags. It leaves the accumulator alone: the write strobe stays low and the result port repeats the accumulator input.

Top module: `alu8_status_unit`

## Requirements
- R1: With `go` high at a rising edge, the next cycle shows `acc_wr_o`=1 and `result_o` = the operation result. `op_sel` encodes 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR and 7 compare. Only codes 1 and 3 use `cy_in`.
- R2: For codes 0 and 1, flag bit 0 (carry) is the carry out of bit 7 of a + b (+ `cy_in` for code 1).
- R3: For codes 2, 3 and 7, flag bit 0 is 1 exactly when a − b (− `cy_in` for code 3) is negative, that is, when a borrow occurs.
- R4: Flag bit 6 (zero) is 1 exactly when the eight-bit result is zero. For compare, the result here means the difference.
- R5: Flag bit 7 (sign) equals bit 7 of that result.
- R6: Flag bit 2 (parity) is 1 exactly when that result has an even number of ones.
- R7: Flag bit 4 (auxiliary carry) is set as follows. For add, it is the carry from bit 3 into bit 4. For subtract and compare, it is 1 when the low nibble of a is smaller than the low nibble of b plus the borrow-in.
- R8: AND, XOR and OR clear both the carry and the auxiliary carry flag.
- R9: Compare sets the flags exactly as subtract does. It gives `acc_wr_o`=0 and `result_o` = `acc_in`.
- R10: Flag bits 5 and 3 are always 0 and flag bit 1 is always 1. After reset the outputs are `result_o`=0, `acc_wr_o`=0 and `flag_byte_o`=8'h02.
- R11: A cycle with `go` low leaves `result_o` and `flag_byte_o` unchanged and drives `acc_wr_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Perform the selected operation this cycle |
| op_sel | input | 3 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| cy_in | input | 1 | Incoming carry/borrow |
| result_o | output | 8 | Registered result |
| acc_wr_o | output | 1 | Accumulator write strobe |
| flag_byte_o | output | 8 | Status byte |

## Verification
The sweep takes every accumulator value against sixteen second operands spread from 0 to 255, with the carry input alternating, under all eight operation codes. This drives the carry, borrow and nibble boundaries at 0x0F/0x10 and 0xFF/0x00.

A design that inverted the sense of carry on subtraction would report a borrow on 5−3 and miss it on 3−5. One that took the nibble carry after the borrow-in, or ignored the borrow-in, would mismatch on pairs such as 0x10−0x00 with borrow.

A compare that wrote the accumulator, or logic operations that left a stale carry, show up on the strobe and bit 0. Idle cycles with changed inputs confirm the outputs hold.

// File: rtl/alu8_status_pkg.sv
package alu8_status_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    localparam int FB_W  = 8;
    localparam int FB_CY = 0;
    localparam int FB_PA = 2;
    localparam int FB_AC = 4;
    localparam int FB_ZE = 6;
    localparam int FB_SG = 7;

    localparam logic [FB_W-1:0] FB_FIXED_MASK = 8'b0010_1010;
    localparam logic [FB_W-1:0] FB_FIXED_VAL  = 8'b0000_0010;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_XOR = 2'd1,
        LG_OR  = 2'd2
    } logic_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              half
);
    localparam int LO_W = DATA_W / 2;
    localparam int HI_W = DATA_W - LO_W;

    logic [DATA_W-1:0] b_eff;
    logic              c0;
    logic [LO_W:0]     lo;
    logic [HI_W:0]     hi;

    always_comb begin
        b_eff = sub ? ~b : b;
        c0    = sub ? ~cin : cin;
        lo    = {1'b0, a[LO_W-1:0]} + {1'b0, b_eff[LO_W-1:0]} + {{LO_W{1'b0}}, c0};
        hi    = {1'b0, a[DATA_W-1:LO_W]} + {1'b0, b_eff[DATA_W-1:LO_W]}
              + {{HI_W{1'b0}}, lo[LO_W]};
        sum   = {hi[HI_W-1:0], lo[LO_W-1:0]};
        // carry for add, borrow for subtract
        cout  = hi[HI_W] ^ sub;
        half  = lo[LO_W] ^ sub;
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic_sel_e        sel,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_XOR:  y = a ^ b;
            LG_OR:   y = a | b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flagpack.sv
module alu8_flagpack
    import alu8_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              cy,
    input  logic              ac,
    output logic [FB_W-1:0]   fb
);
    always_comb begin
        fb        = FB_FIXED_VAL;
        fb[FB_SG] = res[DATA_W-1];
        fb[FB_ZE] = (res == '0);
        fb[FB_AC] = ac;
        fb[FB_PA] = ~(^res);
        fb[FB_CY] = cy;
    end
endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
    import alu8_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              cy_in,
    output logic [DATA_W-1:0] result_o,
    output logic              acc_wr_o,
    output logic [FB_W-1:0]   flag_byte_o
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wr;
        logic [FB_W-1:0]   fb;
    } state_t;

    state_t     st_d, st_q;
    alu_op_e    op;
    logic       is_arith, is_sub, use_cin;
    logic       as_cin;
    logic [DATA_W-1:0] as_sum, lg_y, flag_src;
    logic       as_cout, as_half;
    logic_sel_e lg_sel;
    logic       cy_sel, ac_sel;
    logic [FB_W-1:0] fb_new;

    always_comb begin
        op       = alu_op_e'(op_sel);
        is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB)
                || (op == OP_SBB) || (op == OP_CMP);
        is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        use_cin  = (op == OP_ADC) || (op == OP_SBB);
        as_cin   = use_cin & cy_in;
        case (op)
            OP_AND:  lg_sel = LG_AND;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_OR;
        endcase
    end

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a    (acc_in),
        .b    (opnd_in),
        .cin  (as_cin),
        .sub  (is_sub),
        .sum  (as_sum),
        .cout (as_cout),
        .half (as_half)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .a   (acc_in),
        .b   (opnd_in),
        .sel (lg_sel),
        .y   (lg_y)
    );

    always_comb begin
        flag_src = is_arith ? as_sum : lg_y;
        cy_sel   = is_arith & as_cout;
        ac_sel   = is_arith & as_half;
    end

    alu8_flagpack #(.DATA_W(DATA_W)) u_flags (
        .res (flag_src),
        .cy  (cy_sel),
        .ac  (ac_sel),
        .fb  (fb_new)
    );

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        if (go) begin
            st_d.fb = fb_new;
            if (op == OP_CMP) begin
                st_d.res = acc_in;
            end else begin
                st_d.res = flag_src;
                st_d.wr  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.res <= '0;
            st_q.wr  <= 1'b0;
            st_q.fb  <= FB_FIXED_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o    = st_q.res;
    assign acc_wr_o    = st_q.wr;
    assign flag_byte_o = st_q.fb;

    // R10: spare flag positions keep their fixed values after every operation
    a_r10_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> ((flag_byte_o & FB_FIXED_MASK) == FB_FIXED_VAL));

    // R9: compare never writes and echoes the accumulator input
    a_r9_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == 3'd7) |=> (!acc_wr_o && result_o == $past(acc_in)));

    // R8: logic operations leave carry and auxiliary carry clear
    a_r8_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel[2] && op_sel != 3'd7) |=>
            (!flag_byte_o[FB_CY] && !flag_byte_o[FB_AC]));

    // R4: zero flag agrees with the written result
    a_r4_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel != 3'd7) |=> (flag_byte_o[FB_ZE] == (result_o == '0)));

    // R6: parity flag agrees with the written result
    a_r6_parity_even: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel != 3'd7) |=> (flag_byte_o[FB_PA] == ~(^result_o)));

    // R5: sign flag agrees with the written result
    a_r5_sign_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel != 3'd7) |=> (flag_byte_o[FB_SG] == result_o[DATA_W-1]));

    // R11: idle cycles hold the outputs and drop the strobe
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(result_o) && $stable(flag_byte_o) && !acc_wr_o));

    // R1: every non-compare operation raises the write strobe
    a_r1_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel != 3'd7) |=> acc_wr_o);
endmodule

// File: tb/alu8_status_unit_tb_top.sv
module alu8_status_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] acc_in = 8'd0;
    logic [7:0] opnd_in = 8'd0;
    logic       cy_in = 1'b0;
    logic [7:0] result_o;
    logic       acc_wr_o;
    logic [7:0] flag_byte_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_status_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .op_sel      (op_sel),
        .acc_in      (acc_in),
        .opnd_in     (opnd_in),
        .cy_in       (cy_in),
        .result_o    (result_o),
        .acc_wr_o    (acc_wr_o),
        .flag_byte_o (flag_byte_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic string flag_tag(input int op, input logic [7:0] g, input logic [7:0] e);
        logic [7:0] d;
        d = g ^ e;
        if (d[0]) return (op >= 4 && op <= 6) ? "R8" : ((op == 0 || op == 1) ? "R2" : "R3");
        if (d[4]) return (op >= 4 && op <= 6) ? "R8" : "R7";
        if (d[6]) return "R4";
        if (d[7]) return "R5";
        if (d[2]) return "R6";
        if (d[5] || d[3] || d[1]) return "R10";
        return (op == 7) ? "R9" : "R1";
    endfunction

    task automatic run_vec(input int op, input int a, input int b, input int c);
        int r, cy, ac, pc, er, ew;
        logic [7:0] r8, fb;
        @(negedge clk);
        go = 1'b1; op_sel = 3'(op); acc_in = 8'(a); opnd_in = 8'(b); cy_in = 1'(c);
        @(negedge clk);
        go = 1'b0;
        case (op)
            0, 1: begin
                r  = a + b + ((op == 1) ? c : 0);
                cy = (r > 255) ? 1 : 0;
                ac = (((a & 15) + (b & 15) + ((op == 1) ? c : 0)) > 15) ? 1 : 0;
            end
            2, 3, 7: begin
                r  = a - b - ((op == 3) ? c : 0);
                cy = (r < 0) ? 1 : 0;
                ac = ((a & 15) < ((b & 15) + ((op == 3) ? c : 0))) ? 1 : 0;
            end
            4: begin r = a & b; cy = 0; ac = 0; end
            5: begin r = a ^ b; cy = 0; ac = 0; end
            default: begin r = a | b; cy = 0; ac = 0; end
        endcase
        r8 = 8'(r);
        pc = 0;
        for (int i = 0; i < 8; i++) pc += int'(r8[i]);
        fb = 8'h02;
        fb[7] = r8[7];
        fb[6] = (r8 == 8'd0);
        fb[4] = 1'(ac);
        fb[2] = ((pc % 2) == 0);
        fb[0] = 1'(cy);
        er = (op == 7) ? a : int'(r8);
        ew = (op == 7) ? 0 : 1;
        check((op == 7) ? "R9 result" : "R1 result", int'(result_o), er);
        check((op == 7) ? "R9 strobe" : "R1 strobe", int'(acc_wr_o), ew);
        check(flag_tag(op, flag_byte_o, fb), int'(flag_byte_o), int'(fb));
    endtask

    initial begin
        logic [7:0] keep_r, keep_f;
        #12;
        check("R10 reset result", int'(result_o), 0);
        check("R10 reset strobe", int'(acc_wr_o), 0);
        check("R10 reset flags", int'(flag_byte_o), 8'h02);
        @(negedge clk);
        rst_n = 1'b1;
        // directed corners: R2 R3 R7
        run_vec(0, 8'hFF, 8'h01, 0);
        run_vec(0, 8'h0F, 8'h01, 0);
        run_vec(1, 8'h0F, 8'h00, 1);
        run_vec(2, 3, 5, 0);
        run_vec(2, 5, 3, 0);
        run_vec(3, 8'h10, 8'h00, 1);
        run_vec(7, 8'h42, 8'h42, 1);
        run_vec(1, 8'hFF, 8'hFF, 1);
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 16; k++)
                    run_vec(op, a, k * 17, (a ^ k) & 1);
        // R11: idle cycles with changed inputs hold the outputs
        run_vec(0, 8'h12, 8'h34, 0);
        keep_r = result_o;
        keep_f = flag_byte_o;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            go = 1'b0; op_sel = 3'(i); acc_in = 8'(i * 31); opnd_in = 8'hA5; cy_in = 1'b1;
        end
        @(negedge clk);
        check("R11 hold result", int'(result_o), int'(keep_r));
        check("R11 hold flags", int'(flag_byte_o), int'(keep_f));
        check("R11 strobe low", int'(acc_wr_o), 0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #900000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule